// File: doc/BRIEF.md
# Wide Tapped Delay Pipeline

The block delays a wide data word by a fixed number of clock cycles, so that a word presented at the input leaves at the output a set number of enabled edges later. Each bit lane is built as a cascade of short shift segments. A register closes every segment, and these closing registers count toward the total delay: segment lengths are sized so that the sum of all stages equals the requested depth exactly.

Two groups of interior bits can be read while the data moves. The column tap gives each lane's first stage. The diagonal tap gives lane i at a depth that grows with the lane index and wraps inside the first half of the pipe. A single shift enable moves or freezes the whole structure at once. The data stages carry no reset, so they map onto shift-register resources. A valid flag tells the consumer when the output first carries real data rather than power-up contents.

Top module: `wide_tap_delay`

## Requirements
- R1: When `en` is high at DEPTH clock edges, the word on `din` at the first of those edges appears on `dout` right after the last of them. Edges with `en` low do not count. With defaults, DEPTH is 64.
- R2: At an edge where `en` is low, `dout`, `col_tap` and `diag_tap` all keep their values, whatever `din` does.
- R3: Right after an edge with `en` high, bit i of `col_tap` equals bit i of `din` as sampled at that edge.
- R4: Bit i of `diag_tap` equals bit i of the word that entered k enabled edges ago, where k = 1 + (i mod (DEPTH/2)). Lane 0 therefore matches lane 0 of `col_tap`, and lane DEPTH/2 wraps back to depth 1.
- R5: `out_valid` is 0 after reset. It becomes 1 right after the DEPTH-th edge with `en` high counted from reset release, and it stays 1 until the next reset.
- R6: A synchronous, active-high `rst` clears only `out_valid` and its count. The data stages keep shifting under `en` while reset is high, so `dout` and the taps are undisturbed.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid tracking |
| en | input | 1 | Shift enable for every stage |
| din | input | WIDTH | Data word entering the pipe |
| dout | output | WIDTH | Word delayed by DEPTH enabled edges |
| col_tap | output | WIDTH | First stage of every lane |
| diag_tap | output | WIDTH | Lane i taken at depth 1 + (i mod DEPTH/2) |
| out_valid | output | 1 | High once DEPTH enabled edges have passed since reset |

## Verification
Reset and an enabled shift can land on the same edge. Because the data path has no reset, that edge must clear `out_valid` and still advance every stage. The bench provokes this by holding `rst` high together with `en` for several cycles in the middle of a random run. It then expects `dout` and both taps to keep tracking the reference queue, while the valid count restarts from zero and `out_valid` rises again only after DEPTH more enabled edges.

// File: rtl/wtdp_pkg.sv
package wtdp_pkg;

  function automatic int seg_count(input int depth, input int seg);
    return (depth + seg - 1) / seg;
  endfunction

  function automatic int seg_len(input int depth, input int seg, input int idx);
    int rest;
    rest = depth - idx * seg;
    return (rest < seg) ? rest : seg;
  endfunction

endpackage

// File: rtl/wtdp_seg.sv
module wtdp_seg #(
  parameter int WIDTH = 384,
  parameter int LEN   = 16
) (
  input  logic             clk,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] stages [LEN]
);

  logic [WIDTH-1:0] bnd_q;

  generate
    if (LEN > 1) begin : g_chain
      logic [WIDTH-1:0] sh [LEN-1];
      always_ff @(posedge clk) begin
        if (en) begin
          sh[0] <= d;
          for (int k = 1; k < LEN - 1; k++) sh[k] <= sh[k-1];
          bnd_q <= sh[LEN-2];
        end
      end
      for (genvar k = 0; k < LEN - 1; k++) begin : g_out
        assign stages[k] = sh[k];
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (en) bnd_q <= d;
      end
    end
  endgenerate

  assign stages[LEN-1] = bnd_q;

  // segment boundary register freezes with the enable low
  p_hold_r2: assert property (@(posedge clk) !en |=> $stable(bnd_q))
    else $error("segment boundary moved while enable low");

endmodule

// File: rtl/wtdp_valid.sv
module wtdp_valid #(
  parameter int DEPTH = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic valid
);

  localparam int CW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      valid <= 1'b0;
    end else if (en && !valid) begin
      if (cnt_q == LAST) valid <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  p_valid_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> $past(en))
    else $error("valid rose without an enabled edge");

  p_valid_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    valid |=> valid)
    else $error("valid dropped without reset");

endmodule

// File: rtl/wide_tap_delay.sv
module wide_tap_delay #(
  parameter int WIDTH   = 384,
  parameter int DEPTH   = 64,
  parameter int SEG_LEN = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] col_tap,
  output logic [WIDTH-1:0] diag_tap,
  output logic             out_valid
);

  import wtdp_pkg::*;

  localparam int NSEG = seg_count(DEPTH, SEG_LEN);
  localparam int HALF = (DEPTH / 2 > 0) ? DEPTH / 2 : 1;

  initial begin
    p_geom_ok: assert (SEG_LEN >= 1 && SEG_LEN <= 16 && DEPTH >= 1)
      else $error("segment length must be 1..16 and depth positive");
  end

  // stg[n] holds the word entered n+1 enabled edges ago
  logic [WIDTH-1:0] stg [DEPTH];

  generate
    for (genvar s = 0; s < NSEG; s++) begin : g_seg
      localparam int BASE = s * SEG_LEN;
      localparam int LEN  = seg_len(DEPTH, SEG_LEN, s);
      logic [WIDTH-1:0] seg_in;
      logic [WIDTH-1:0] seg_st [LEN];
      if (s == 0) begin : g_head
        assign seg_in = din;
      end else begin : g_link
        assign seg_in = stg[BASE-1];
      end
      wtdp_seg #(.WIDTH(WIDTH), .LEN(LEN)) u_seg (
        .clk    (clk),
        .en     (en),
        .d      (seg_in),
        .stages (seg_st)
      );
      for (genvar k = 0; k < LEN; k++) begin : g_map
        assign stg[BASE+k] = seg_st[k];
      end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_diag
      assign diag_tap[i] = stg[i % HALF][i];
    end
  endgenerate

  assign col_tap = stg[0];
  assign dout    = stg[DEPTH-1];

  wtdp_valid #(.DEPTH(DEPTH)) u_valid (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .valid (out_valid)
  );

  p_col_r3: assert property (@(posedge clk) disable iff (rst)
    en |=> col_tap == $past(din))
    else $error("column tap does not follow input");

  generate
    if (HALF >= 2 && WIDTH >= 2) begin : g_diag_chk
      p_diag_r4: assert property (@(posedge clk) disable iff (rst)
        en |=> diag_tap[1] == $past(col_tap[1]))
        else $error("diagonal lane 1 not one stage behind column");
    end
    if (DEPTH >= 2) begin : g_out_chk
      p_out_r1: assert property (@(posedge clk) disable iff (rst)
        en |=> dout == $past(stg[DEPTH-2]))
        else $error("output not fed from the stage before it");
    end
  endgenerate

endmodule

// File: tb/wide_tap_delay_tb.sv
module wide_tap_delay_tb_top;

  localparam int WIDTH = 384;
  localparam int DEPTH = 64;
  localparam int HALF  = DEPTH / 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en  = 1'b0;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] dout, col_tap, diag_tap;
  logic             out_valid;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [WIDTH-1:0] mdl [DEPTH];
  int dfill = 0;
  int vcnt  = 0;

  always #4 clk = ~clk;

  wide_tap_delay #(.WIDTH(WIDTH), .DEPTH(DEPTH), .SEG_LEN(16)) dut_i (
    .clk(clk), .rst(rst), .en(en), .din(din),
    .dout(dout), .col_tap(col_tap), .diag_tap(diag_tap), .out_valid(out_valid)
  );

  function automatic logic [WIDTH-1:0] rnd_word();
    logic [WIDTH-1:0] w = '0;
    for (int k = 0; k < (WIDTH + 31) / 32; k++) w = (w << 32) | WIDTH'($urandom);
    return w;
  endfunction

  task automatic chk_vec(input string tag, input logic [WIDTH-1:0] act,
                         input logic [WIDTH-1:0] exp, input logic [WIDTH-1:0] msk);
    n_run++;
    if ((act & msk) !== (exp & msk)) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act & msk, exp & msk);
    end
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic e, input logic [WIDTH-1:0] d);
    logic [WIDTH-1:0] exp_d, msk_d;
    string tg;
    @(negedge clk);
    rst = r; en = e; din = d;
    @(posedge clk);
    #3;
    if (e) begin
      for (int k = DEPTH - 1; k > 0; k--) mdl[k] = mdl[k-1];
      mdl[0] = d;
      if (dfill < DEPTH) dfill++;
    end
    if (r) vcnt = 0;
    else if (e && vcnt < DEPTH) vcnt++;
    tg = r ? "R6" : (e ? "" : "R2");
    if (dfill >= DEPTH) chk_vec({"R1 dout ", tg}, dout, mdl[DEPTH-1], '1);
    if (dfill >= 1)     chk_vec({"R3 col_tap ", tg}, col_tap, mdl[0], '1);
    exp_d = '0; msk_d = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (dfill > i % HALF) begin
        exp_d[i] = mdl[i % HALF][i];
        msk_d[i] = 1'b1;
      end
    end
    chk_vec({"R4 diag_tap ", tg}, diag_tap, exp_d, msk_d);
    chk_bit("R5 out_valid", out_valid, vcnt >= DEPTH);
  endtask

  initial begin
    void'($urandom(32'd20417));
    // reset state
    repeat (3) step(1'b1, 1'b0, '0);
    chk_bit("R5 valid low in reset", out_valid, 1'b0);
    // fill with exactly DEPTH-1 enabled edges, then the last one
    for (int c = 0; c < DEPTH - 1; c++) step(1'b0, 1'b1, rnd_word());
    chk_bit("R5 valid before last fill edge", out_valid, 1'b0);
    step(1'b0, 1'b1, rnd_word());
    chk_bit("R5 valid on DEPTH-th edge", out_valid, 1'b1);
    // hold with changing input
    for (int c = 0; c < 20; c++) step(1'b0, 1'b0, rnd_word());
    // directed patterns
    step(1'b0, 1'b1, '1);
    step(1'b0, 1'b1, '0);
    for (int c = 0; c < WIDTH / 8; c++) step(1'b0, 1'b1, WIDTH'(1) << c);
    // random run with enable gaps
    for (int c = 0; c < 3000; c++) step(1'b0, ($urandom % 4) != 0, rnd_word());
    // reset during shifting
    for (int c = 0; c < 4; c++) step(1'b1, 1'b1, rnd_word());
    chk_bit("R6 valid cleared under reset", out_valid, 1'b0);
    for (int c = 0; c < 400; c++) step(1'b0, ($urandom % 3) != 0, rnd_word());
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule